// File: doc/BRIEF.md
# Eight-Level Priority Interrupt Controller with Poll Read

This block collects eight interrupt lines, latches a request on each rising edge, and tells the host through a single interrupt output when a request is waiting that outranks everything already being serviced. Level 0 has the highest priority and level 7 the lowest. The host reaches the block through a byte-wide register bus with a single address bit, so there are two ports: an even port (address bit low) and an odd port (address bit high).

The host first writes a short setup sequence. A word with bit 4 set, written to the even port, restarts setup. It is followed by one to three words on the odd port: word 2 always, word 3 only in cascade configuration, and word 4 only when asked for. These words are consumed, so cascade wiring can be described the same way on a master or on a slave instance. After setup, odd-port writes load the mask. Even-port writes are end-of-interrupt or read-select/poll commands. In poll mode the next even-port read returns the winning level directly and acknowledges it, so the host never needs an acknowledge bus cycle.

Read data is combinational from the current state while the read strobe is high. Any side effect of a read, such as a poll acknowledge, takes place at the clock edge that ends the read cycle.

Top module: `prio_intc`

## Requirements
- R1: After reset the mask reads 0xFF, the request and in-service registers are 0, even-port reads return the request register, and `int_out` is low.
- R2: A rising edge on `irq_in[k]` sets request bit k at the next clock edge. A line held high does not set the bit again once it has been cleared; only a new low-to-high transition does.
- R3: An even-port write with bit 4 set starts setup. It clears the mask to 0x00 and clears the request and in-service registers. It selects the request register for even-port reads and cancels a pending poll.
- R4: During setup, the first odd-port write is word 2. Word 3 follows only if word 1 bit 1 is 0 (cascade configuration). Word 4 follows only if word 1 bit 0 is 1. The next odd-port write after the sequence loads the mask. Example values: 0x11 takes three words, 0x13 takes two, 0x12 takes one and 0x10 takes two.
- R5: After setup, odd-port writes load the mask (bit k set masks level k), and odd-port reads return the mask.
- R6: `int_out` is high exactly when some unmasked request has a lower level number than every set in-service bit, or when an unmasked request exists and the in-service register is 0.
- R7: An even-port write with bits 4:3 = 01 and bit 1 = 1 selects the register returned by even-port reads: bit 0 = 0 selects the request register and bit 0 = 1 selects the in-service register. With bit 1 = 0 the selection is kept.
- R8: An even-port write with bits 4:3 = 01 and bit 2 = 1 arms poll mode. The next even-port read returns bit 7 = an interrupt is pending (as for R6), bits 2:0 = the winning level (0 if none is pending), and bits 6:3 = 0. Later even-port reads return the selected register again.
- R9: A poll read that finds a pending request clears that level's request bit and sets its in-service bit at the edge that ends the read. A poll read that finds none changes neither register.
- R10: An even-port write with bits 4:3 = 00 and bit 5 = 1 clears in-service bit [2:0]. With bit 5 = 0 it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_a0 | input | 1 | Port select: 0 = even port, 1 = odd port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while `bus_rd` is high |
| irq_in | input | 8 | Interrupt lines, edge-sensitive, level 0 highest |
| int_out | output | 1 | Interrupt pending to host |

## Verification
A line edge shows in the request register, and therefore in `int_out`, after the first clock edge that sees the line high. The bench raises a line one cycle before it probes. A write takes effect at the edge that ends its strobe cycle, so the bench issues each read or probe on a later cycle. Read data is compared in the middle of the strobe cycle, before the poll acknowledge edge. A following read then confirms that the request moved into service at that edge.

// File: rtl/intc_pkg.sv
// Shared types and field positions for the priority interrupt controller.
// Assumes a byte-wide host bus.
package intc_pkg;
    typedef enum logic [1:0] {ST_RUN, ST_W2, ST_W3, ST_W4} init_st_t;

    localparam int BUS_W      = 8;
    localparam int BIT_START  = 4;   // even-port word 1 marker
    localparam int BIT_SINGLE = 1;   // word 1: no cascade word
    localparam int BIT_NEED4  = 0;   // word 1: word 4 follows
    localparam int BIT_EOI    = 5;   // end-of-interrupt enable
    localparam int BIT_POLL   = 2;   // command: arm poll
    localparam int BIT_SELV   = 1;   // command: read-select valid
    localparam int BIT_SELISR = 0;   // command: select in-service
endpackage

// File: rtl/intc_edge.sv
// Request register. Each line has an edge detector. A rising edge sets
// the bit. An acknowledge or a setup flush clears it, and a new edge in
// the same cycle wins over the clear.
module intc_edge #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lines_i,
    input  logic [N-1:0] ack_i,
    input  logic         flush_i,
    output logic [N-1:0] irr_o
);
    logic [N-1:0] prev_q;
    logic [N-1:0] irr_q;

    for (genvar k = 0; k < N; k++) begin : g_bit
        // Track line history and keep the request bit for this level.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prev_q[k] <= 1'b0;
                irr_q[k]  <= 1'b0;
            end else begin
                prev_q[k] <= lines_i[k];
                if (lines_i[k] && !prev_q[k])
                    irr_q[k] <= 1'b1;
                else if (ack_i[k] || flush_i)
                    irr_q[k] <= 1'b0;
            end
        end

        AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
            (lines_i[k] && !prev_q[k]) |=> irr_q[k]); // R2
    end

    assign irr_o = irr_q;
endmodule

// File: rtl/intc_resolver.sv
// Fixed-priority resolver. Level 0 is the highest. It finds the winning
// unmasked request and the top in-service level, and says whether the
// request outranks service. Purely combinational.
module intc_resolver #(
    parameter int N  = 8,
    localparam int LW = $clog2(N)
) (
    input  logic [N-1:0]  irr_i,
    input  logic [N-1:0]  mask_i,
    input  logic [N-1:0]  isr_i,
    output logic          pend_o,
    output logic [LW-1:0] level_o
);
    logic [N-1:0]  mreq;
    logic [LW-1:0] req_lv;
    logic [LW-1:0] isr_lv;
    logic          isr_any;

    assign mreq = irr_i & ~mask_i;

    // Scan from the lowest priority upward so the smallest index wins.
    always_comb begin
        req_lv  = '0;
        isr_lv  = '0;
        isr_any = 1'b0;
        for (int k = N - 1; k >= 0; k--) begin
            if (mreq[k])  req_lv = LW'(k);
            if (isr_i[k]) begin
                isr_lv  = LW'(k);
                isr_any = 1'b1;
            end
        end
    end

    assign pend_o  = (|mreq) && (!isr_any || (req_lv < isr_lv));
    assign level_o = pend_o ? req_lv : '0;
endmodule

// File: rtl/intc_ctrl.sv
// Bus decode, setup sequencer, mask, in-service, read select and poll.
// Assumes one strobe per cycle from the host. Read data is combinational.
module intc_ctrl
    import intc_pkg::*;
#(
    parameter int N  = 8,
    localparam int LW = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic             bus_a0,
    input  logic [BUS_W-1:0] bus_wdata,
    input  logic [N-1:0]     irr_i,
    input  logic             pend_i,
    input  logic [LW-1:0]    level_i,
    output logic [BUS_W-1:0] rdata_o,
    output logic [N-1:0]     mask_o,
    output logic [N-1:0]     isr_o,
    output logic [N-1:0]     ack_o,
    output logic             flush_o
);
    init_st_t     st_q;
    logic         single_q, need4_q, sel_isr_q, poll_q;
    logic [N-1:0] mask_q, isr_q;

    logic wr_even, wr_odd, is_w1, run, is_eoi, is_cmd, poll_rd;

    assign wr_even = bus_wr && !bus_a0;
    assign wr_odd  = bus_wr &&  bus_a0;
    assign is_w1   = wr_even && bus_wdata[BIT_START];
    assign run     = (st_q == ST_RUN);
    assign is_eoi  = wr_even && run && (bus_wdata[4:3] == 2'b00) && bus_wdata[BIT_EOI];
    assign is_cmd  = wr_even && run && (bus_wdata[4:3] == 2'b01);
    assign poll_rd = bus_rd && !bus_a0 && poll_q;
    assign flush_o = is_w1;

    // Acknowledge vector: the winning level, on a pending poll read.
    always_comb begin
        ack_o = '0;
        if (poll_rd && pend_i) ack_o[level_i] = 1'b1;
    end

    // Setup sequencer: word 1 restarts it, odd writes walk words 2 to 4.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_RUN;
            single_q <= 1'b1;
            need4_q  <= 1'b0;
        end else if (is_w1) begin
            st_q     <= ST_W2;
            single_q <= bus_wdata[BIT_SINGLE];
            need4_q  <= bus_wdata[BIT_NEED4];
        end else if (wr_odd) begin
            case (st_q)
                ST_W2:   st_q <= !single_q ? ST_W3 : (need4_q ? ST_W4 : ST_RUN);
                ST_W3:   st_q <= need4_q ? ST_W4 : ST_RUN;
                ST_W4:   st_q <= ST_RUN;
                default: st_q <= ST_RUN;
            endcase
        end
    end

    // Mask register: cleared by word 1, loaded by odd writes after setup.
    always_ff @(posedge clk) begin
        if (!rst_n)            mask_q <= '1;
        else if (is_w1)        mask_q <= '0;
        else if (wr_odd && run) mask_q <= bus_wdata[N-1:0];
    end

    // In-service register: poll acknowledge sets, end of interrupt clears.
    always_ff @(posedge clk) begin
        if (!rst_n || is_w1) begin
            isr_q <= '0;
        end else begin
            for (int k = 0; k < N; k++) begin
                if (ack_o[k])
                    isr_q[k] <= 1'b1;
                else if (is_eoi && (bus_wdata[LW-1:0] == LW'(k)))
                    isr_q[k] <= 1'b0;
            end
        end
    end

    // Read select and poll arm: set by commands, poll ends on its read.
    always_ff @(posedge clk) begin
        if (!rst_n || is_w1) begin
            sel_isr_q <= 1'b0;
            poll_q    <= 1'b0;
        end else if (is_cmd) begin
            if (bus_wdata[BIT_SELV]) sel_isr_q <= bus_wdata[BIT_SELISR];
            poll_q <= bus_wdata[BIT_POLL];
        end else if (poll_rd) begin
            poll_q <= 1'b0;
        end
    end

    // Read mux: odd port gives mask, even port gives poll byte or register.
    always_comb begin
        if (bus_a0)         rdata_o = BUS_W'(mask_q);
        else if (poll_q)    rdata_o = {pend_i, {(BUS_W-1-LW){1'b0}}, level_i};
        else if (sel_isr_q) rdata_o = BUS_W'(isr_q);
        else                rdata_o = BUS_W'(irr_i);
    end

    assign mask_o = mask_q;
    assign isr_o  = isr_q;

    AST_W1_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        is_w1 |=> (mask_q == '0 && isr_q == '0 && !poll_q)); // R3
    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_odd && run) |=> (mask_q == $past(bus_wdata[N-1:0]))); // R5
    AST_EOI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (is_eoi && !bus_rd) |=> !isr_q[$past(bus_wdata[LW-1:0])]); // R10
    AST_POLL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_rd && pend_i && !bus_wr) |=> isr_q[$past(level_i)]); // R9
    AST_POLL_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_rd && !bus_wr) |=> !poll_q); // R8
    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack_o)); // R9
endmodule

// File: rtl/prio_intc.sv
// Top of the eight-level priority interrupt controller. It ties the
// request register, the resolver and the bus control together. Assumes
// that irq_in is synchronous to clk.
module prio_intc
    import intc_pkg::*;
#(
    parameter int N = 8,
    localparam int LW = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic             bus_a0,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic [N-1:0]     irq_in,
    output logic             int_out
);
    logic [N-1:0]  irr, mask, isr, ack;
    logic          flush, pend;
    logic [LW-1:0] level;

    intc_edge #(.N(N)) u_edge (
        .clk(clk), .rst_n(rst_n), .lines_i(irq_in), .ack_i(ack),
        .flush_i(flush), .irr_o(irr)
    );

    intc_resolver #(.N(N)) u_res (
        .irr_i(irr), .mask_i(mask), .isr_i(isr),
        .pend_o(pend), .level_o(level)
    );

    intc_ctrl #(.N(N)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_a0(bus_a0), .bus_wdata(bus_wdata), .irr_i(irr),
        .pend_i(pend), .level_i(level), .rdata_o(bus_rdata),
        .mask_o(mask), .isr_o(isr), .ack_o(ack), .flush_o(flush)
    );

    assign int_out = pend;

    AST_INT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> ((irr & ~mask) != '0)); // R6
    AST_INT_OUTRANKS: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> ((isr & ((N'(1) << level) - N'(1))) == '0 && !isr[level])); // R6
endmodule

// File: tb/sim_prio_intc.sv
// Scoreboard bench. Driver tasks push expected items into a queue, and a
// monitor at the falling edge pops and compares each one.
module sim_prio_intc;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0, bus_a0 = 1'b0, probe = 1'b0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic [7:0] irq_in = '0;
    logic       int_out;
    bit         done = 1'b0;

    typedef struct { logic [7:0] val; string tag; } exp_t;
    exp_t q[$];
    int tests = 0, fails = 0;

    always #10 clk = ~clk;   // 50 MHz

    prio_intc u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_a0(bus_a0), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_in(irq_in), .int_out(int_out)
    );

    // Monitor: compare a read or an interrupt probe against the queue head.
    always @(negedge clk) begin
        if (bus_rd || probe) begin
            exp_t e;
            logic [7:0] act;
            act = bus_rd ? bus_rdata : {7'b0, int_out};
            tests++;
            if (q.size() == 0) begin
                fails++;
                $display("FAIL %s: no expectation queued, actual 0x%02h", "scoreboard", act);
            end else begin
                e = q.pop_front();
                if (act !== e.val) begin
                    fails++;
                    $display("FAIL %s: actual 0x%02h expected 0x%02h", e.tag, act, e.val);
                end
            end
        end
    end

    task automatic wr(input logic a0, input logic [7:0] d);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_a0 = a0; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic a0, input logic [7:0] exp, input string tag);
        q.push_back('{exp, tag});
        @(posedge clk); #1;
        bus_rd = 1'b1; bus_a0 = a0;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic chk_int(input logic exp, input string tag);
        q.push_back('{{7'b0, exp}, tag});
        @(posedge clk); #1;
        probe = 1'b1;
        @(posedge clk); #1;
        probe = 1'b0;
    endtask

    task automatic line(input int k, input logic v);
        @(posedge clk); #1;
        irq_in[k] = v;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        rd(1'b0, 8'h00, "R1 request reg after reset");
        rd(1'b1, 8'hFF, "R1 mask after reset");
        chk_int(1'b0, "R1 int low after reset");

        // Setup with cascade and word 4: three odd words.
        wr(1'b0, 8'h11);
        rd(1'b1, 8'h00, "R3 word 1 clears mask");
        wr(1'b1, 8'h08); wr(1'b1, 8'h04); wr(1'b1, 8'h01);
        rd(1'b1, 8'h00, "R4 words 2-4 not loaded as mask");
        wr(1'b1, 8'hF0);
        rd(1'b1, 8'hF0, "R5 mask load and read");

        line(5, 1'b1);
        rd(1'b0, 8'h20, "R2 edge on line 5 latched");
        chk_int(1'b0, "R6 masked request gives no int");
        line(2, 1'b1);
        chk_int(1'b1, "R6 unmasked request raises int");

        wr(1'b0, 8'h0B);
        rd(1'b0, 8'h00, "R7 in-service select");
        wr(1'b0, 8'h0A);
        rd(1'b0, 8'h24, "R7 request select");

        wr(1'b0, 8'h0E);
        rd(1'b0, 8'h82, "R8 poll returns level 2");
        rd(1'b0, 8'h20, "R8 after poll read returns request reg");
        wr(1'b0, 8'h0B);
        rd(1'b0, 8'h04, "R9 poll moved level 2 into service");
        chk_int(1'b0, "R6 only masked request left");

        wr(1'b1, 8'h00);
        chk_int(1'b0, "R6 level 5 below level 2 in service");
        line(1, 1'b1);
        chk_int(1'b1, "R6 level 1 outranks level 2 in service");

        wr(1'b0, 8'h0C);
        rd(1'b0, 8'h81, "R8 poll returns level 1");
        rd(1'b0, 8'h06, "R9 levels 1 and 2 in service");
        wr(1'b0, 8'h0C);
        rd(1'b0, 8'h00, "R8 poll with nothing above service");
        rd(1'b0, 8'h06, "R9 empty poll leaves service unchanged");

        wr(1'b0, 8'h21);
        rd(1'b0, 8'h04, "R10 EOI clears level 1");
        wr(1'b0, 8'h02);
        rd(1'b0, 8'h04, "R10 bit 5 clear has no effect");
        wr(1'b0, 8'h22);
        rd(1'b0, 8'h00, "R10 EOI clears level 2");
        chk_int(1'b1, "R6 level 5 pending with empty service");

        wr(1'b0, 8'h0C);
        rd(1'b0, 8'h85, "R8 poll returns level 5");
        rd(1'b0, 8'h20, "R9 level 5 in service");
        wr(1'b0, 8'h0A);
        rd(1'b0, 8'h00, "R2 held lines do not re-latch");
        line(1, 1'b0);
        line(1, 1'b1);
        rd(1'b0, 8'h02, "R2 new edge on line 1 latched");

        // Single, with word 4: two odd words.
        wr(1'b0, 8'h13);
        rd(1'b0, 8'h00, "R3 word 1 clears requests");
        wr(1'b0, 8'h0B);
        rd(1'b0, 8'h00, "R3 word 1 cleared service, command ignored in setup");
        wr(1'b1, 8'h40); wr(1'b1, 8'h01); wr(1'b1, 8'h55);
        rd(1'b1, 8'h55, "R4 single with word 4");

        // Single, no word 4: one odd word.
        wr(1'b0, 8'h12);
        wr(1'b1, 8'h40); wr(1'b1, 8'h3C);
        rd(1'b1, 8'h3C, "R4 single without word 4");

        // Cascade, no word 4: two odd words.
        wr(1'b0, 8'h10);
        wr(1'b1, 8'h40); wr(1'b1, 8'h02); wr(1'b1, 8'h99);
        rd(1'b1, 8'h99, "R4 cascade without word 4");

        repeat (2) @(posedge clk);
        if (q.size() != 0) begin
            tests++; fails++;
            $display("FAIL scoreboard: actual %0d items left expected 0", q.size());
        end
        done = 1'b1;
        finish_run();
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual hung expected completion");
            finish_run();
        end
    end
endmodule